// File: doc/BRIEF.md
# LIN Transmit Timeout and Bus Stuck-Dominant Guard

This block protects a LIN transceiver against two faults. The first is a local transmit-data line that stays dominant for too long. The second is a bus that is already dominant when the device goes to sleep. It watches the transmit-data level, the received bus level and the operating mode, and counts time in ticks of an external timebase.

While the transceiver is in normal or fast mode, a transmit line held dominant for a set number of ticks turns the driver off. The same event raises a sticky fault flag and an interrupt request. The driver comes back only when the transmit line is recessive again and the fault has been cleared by the clear strobe, or when the mode is left and re-entered.

When the mode changes into sleep while the bus reads dominant, the block locks out wake-up detection. The lockout is released only by a recessive bus level that stays steady for a filter time, so short glitches cannot release it. Both detections take effect on the clock edge that detects the fault, which keeps the reporting delay to one clock.

There is no data stream through this block. All pins are plain control and status levels, sampled on every clock edge, with no handshake.

Top module: `lin_txd_bus_guard`

## Requirements
- R1: While reset is asserted, the fault flag, wake lockout and interrupt request are low and any driver block is cleared.
- R2: Mode encoding is 0 = sleep, 1 = standby, 2 = normal, 3 = fast. Without a pending block, the transmitter enable is high exactly in normal or fast mode.
- R3: The transmit line is dominant at level 0. In normal or fast mode, the fault flag and interrupt rise and the transmitter enable falls on the clock edge that carries the TMO_TICKS-th consecutive tick with the transmit line dominant. After TMO_TICKS-1 such ticks, none of these outputs has changed.
- R4: A single clock cycle with the transmit line recessive (1) restarts the timeout count.
- R5: In sleep or standby mode the timeout does not count. On entry to normal mode the count starts from zero.
- R6: A clear strobe while the transmit line is dominant has no effect: the fault, the interrupt and the driver block all remain.
- R7: A clear strobe while the transmit line is recessive clears the fault flag and the interrupt, and re-enables the transmitter, on that edge. A recessive level alone without a clear strobe keeps the driver blocked.
- R8: Leaving normal or fast mode and re-entering it with the transmit line recessive re-enables the transmitter, while the fault flag stays set. Re-entering with the line dominant keeps the driver blocked.
- R9: A mode change into sleep while the bus reads dominant (0) raises the wake lockout and the interrupt on that edge.
- R10: A mode change into sleep while the bus reads recessive raises neither. A bus that turns dominant while already in sleep does not set the lockout.
- R11: The wake lockout clears only after the bus has read recessive for FILT_TICKS consecutive ticks, on the following clock edge with the bus still recessive. A shorter recessive burst leaves it set.
- R12: Clock cycles without a timebase tick do not advance either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (0 sleep, 1 standby, 2 normal, 3 fast) |
| txd_i | input | 1 | Local transmit-data level, 0 = dominant |
| bus_i | input | 1 | Received bus level, 0 = dominant |
| tick_i | input | 1 | Timebase tick, one clock wide |
| clr_i | input | 1 | Fault and interrupt clear strobe |
| tx_en_o | output | 1 | Transmitter driver enable |
| wake_lock_o | output | 1 | Wake-up detection lockout |
| fault_o | output | 1 | Sticky transmit-timeout fault flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that every input is synchronous to the clock and stays defined from reset onward. They also assume that the clear strobe and the mode are sampled as levels on each edge, so a mode change or a clear counts on exactly one edge. The bench keeps to this by changing inputs only just after a rising edge, one scenario at a time, with a full reset before each scenario. It holds the tick high except in the scenario that gates it, so cycle counts map directly onto tick counts.

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_FAST    = 2'b11
  } lin_mode_e;

  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  function automatic logic mode_drives(input logic [1:0] m);
    return (m == MODE_NORMAL) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/lin_run_counter.sv
// Counts timebase ticks for which a level stays at TARGET without a break.
// EDGE_OUT picks the output: 1 = pulse on the tick that completes the run,
// 0 = level that stays high while the full run has been seen.
module lin_run_counter #(
  parameter int   TICKS    = 80,
  parameter logic TARGET   = 1'b0,
  parameter bit   EDGE_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic level_i,
  input  logic tick_i,
  output logic out_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS);
  localparam logic [CW-1:0] PREV = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          run_ok;

  assign run_ok = arm_i && (level_i == TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_ok) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  generate
    if (EDGE_OUT) begin : g_pulse
      assign out_o = run_ok && tick_i && (cnt_q == PREV);
    end else begin : g_level
      assign out_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/lin_tx_guard.sv
// Driver block and sticky fault flag for the transmit-timeout monitor.
module lin_tx_guard
  import lin_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic txd_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic tx_en_o,
  output logic fault_o
);
  logic active_q;
  logic block_q;
  logic fault_q;
  logic entry;
  logic line_rec;

  assign entry    = active_i && !active_q;
  assign line_rec = (txd_i == LVL_REC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_i;
    end
  end

  // Release needs a recessive line plus a clear or a fresh mode entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block_q <= 1'b0;
    end else if (hit_i) begin
      block_q <= 1'b1;
    end else if (line_rec && (clr_i || entry)) begin
      block_q <= 1'b0;
    end
  end

  // Sticky flag: only a qualified clear removes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (hit_i) begin
      fault_q <= 1'b1;
    end else if (line_rec && clr_i) begin
      fault_q <= 1'b0;
    end
  end

  assign tx_en_o = active_i && !block_q;
  assign fault_o = fault_q;

endmodule

// File: rtl/lin_wake_lock.sv
// Samples the bus on entry to sleep; locks wake-up on a dominant bus.
module lin_wake_lock
  import lin_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic bus_i,
  input  logic rec_ok_i,
  output logic lock_o,
  output logic set_o
);
  logic sleep_q;
  logic lock_q;

  assign set_o = sleep_i && !sleep_q && (bus_i == LVL_DOM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
    end else begin
      sleep_q <= sleep_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (set_o) begin
      lock_q <= 1'b1;
    end else if (rec_ok_i && (bus_i == LVL_REC)) begin
      lock_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/lin_txd_bus_guard.sv
module lin_txd_bus_guard
  import lin_guard_pkg::*;
#(
  parameter int TMO_TICKS  = 80,
  parameter int FILT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       txd_i,
  input  logic       bus_i,
  input  logic       tick_i,
  input  logic       clr_i,
  output logic       tx_en_o,
  output logic       wake_lock_o,
  output logic       fault_o,
  output logic       irq_o
);
  logic active;
  logic in_sleep;
  logic tmo_hit;
  logic rec_ok;
  logic lock_set;
  logic irq_q;

  assign active   = mode_drives(mode_i);
  assign in_sleep = (mode_i == MODE_SLEEP);

  lin_run_counter #(
    .TICKS   (TMO_TICKS),
    .TARGET  (LVL_DOM),
    .EDGE_OUT(1'b1)
  ) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (active),
    .level_i(txd_i),
    .tick_i (tick_i),
    .out_o  (tmo_hit)
  );

  lin_run_counter #(
    .TICKS   (FILT_TICKS),
    .TARGET  (LVL_REC),
    .EDGE_OUT(1'b0)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (1'b1),
    .level_i(bus_i),
    .tick_i (tick_i),
    .out_o  (rec_ok)
  );

  lin_tx_guard u_txg (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(active),
    .txd_i   (txd_i),
    .hit_i   (tmo_hit),
    .clr_i   (clr_i),
    .tx_en_o (tx_en_o),
    .fault_o (fault_o)
  );

  lin_wake_lock u_wlk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (in_sleep),
    .bus_i   (bus_i),
    .rec_ok_i(rec_ok),
    .lock_o  (wake_lock_o),
    .set_o   (lock_set)
  );

  // A new detection wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (tmo_hit || lock_set) begin
      irq_q <= 1'b1;
    end else if (clr_i && (txd_i == LVL_REC)) begin
      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/lin_txd_bus_guard_chk.sv
module lin_txd_bus_guard_chk
  import lin_guard_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       txd_i,
  input logic       bus_i,
  input logic       clr_i,
  input logic       tx_en_o,
  input logic       wake_lock_o,
  input logic       fault_o,
  input logic       irq_o
);

  // R3
  fault_cuts_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (irq_o && !tx_en_o));

  // R5
  fault_only_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> mode_drives($past(mode_i)));

  // R6
  clear_on_dominant_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && clr_i && !txd_i) |=> fault_o);

  // R7
  fault_release_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o) |-> ($past(clr_i) && $past(txd_i)));

  // R9
  lock_from_dominant_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_lock_o) |-> (($past(mode_i) == MODE_SLEEP) && !$past(bus_i)));

  // R11
  lock_held_on_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_lock_o && !bus_i) |=> wake_lock_o);

endmodule

bind lin_txd_bus_guard lin_txd_bus_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .txd_i      (txd_i),
  .bus_i      (bus_i),
  .clr_i      (clr_i),
  .tx_en_o    (tx_en_o),
  .wake_lock_o(wake_lock_o),
  .fault_o    (fault_o),
  .irq_o      (irq_o)
);

// File: tb/lin_txd_bus_guard_tb.sv
module lin_txd_bus_guard_tb;
  import lin_guard_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 12;
  localparam int FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = MODE_SLEEP;
  logic       txd = 1'b1;
  logic       bus = 1'b1;
  logic       tick = 1'b1;
  logic       clr = 1'b0;
  logic       tx_en, wake_lock, fault, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_txd_bus_guard #(.TMO_TICKS(TMO), .FILT_TICKS(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .txd_i(txd), .bus_i(bus),
    .tick_i(tick), .clr_i(clr), .tx_en_o(tx_en), .wake_lock_o(wake_lock),
    .fault_o(fault), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode = MODE_SLEEP; txd = 1'b1; bus = 1'b1; tick = 1'b1; clr = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic strobe_clear();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  // Drives a full timeout from normal mode and checks its edge (R3).
  task automatic force_timeout();
    mode = MODE_NORMAL; txd = 1'b1; step(1);
    txd = 1'b0; step(TMO - 1);
    chk("R3", "fault before limit", fault, 1'b0);
    chk("R3", "tx_en before limit", tx_en, 1'b1);
    step(1);
    chk("R3", "fault at limit", fault, 1'b1);
    chk("R3", "tx_en at limit", tx_en, 1'b0);
    chk("R3", "irq at limit", irq, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = MODE_SLEEP; step(2);
    chk("R1", "fault in reset", fault, 1'b0);
    chk("R1", "lock in reset", wake_lock, 1'b0);
    chk("R1", "irq in reset", irq, 1'b0);
    chk("R1", "tx_en in reset", tx_en, 1'b0);
    rst_n = 1'b1; step(1);
    mode = MODE_NORMAL;  step(1); chk("R2", "tx_en normal", tx_en, 1'b1);
    mode = MODE_STANDBY; step(1); chk("R2", "tx_en standby", tx_en, 1'b0);
    mode = MODE_FAST;    step(1); chk("R2", "tx_en fast", tx_en, 1'b1);
    mode = MODE_SLEEP;   step(1); chk("R2", "tx_en sleep", tx_en, 1'b0);
  endtask

  task automatic t_clear_rules();
    do_reset();
    force_timeout();
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R6", "fault after dominant clear", fault, 1'b1);
    chk("R6", "irq after dominant clear", irq, 1'b1);
    chk("R6", "tx_en after dominant clear", tx_en, 1'b0);
    txd = 1'b1; step(2);
    chk("R7", "tx_en recessive without clear", tx_en, 1'b0);
    strobe_clear();
    chk("R7", "fault after clear", fault, 1'b0);
    chk("R7", "irq after clear", irq, 1'b0);
    chk("R7", "tx_en after clear", tx_en, 1'b1);
  endtask

  task automatic t_reentry();
    do_reset();
    force_timeout();
    mode = MODE_STANDBY; step(2);
    mode = MODE_NORMAL; step(1);
    chk("R8", "tx_en reentry dominant", tx_en, 1'b0);
    txd = 1'b1; step(2);
    chk("R8", "tx_en recessive no reentry", tx_en, 1'b0);
    mode = MODE_STANDBY; step(2);
    mode = MODE_FAST; step(1);
    chk("R8", "tx_en reentry recessive", tx_en, 1'b1);
    chk("R8", "fault stays sticky", fault, 1'b1);
  endtask

  task automatic t_recessive_restart();
    do_reset();
    mode = MODE_NORMAL; txd = 1'b0; step(TMO - 1);
    txd = 1'b1; step(1);
    txd = 1'b0; step(TMO - 1);
    chk("R4", "fault after split run", fault, 1'b0);
    chk("R4", "tx_en after split run", tx_en, 1'b1);
    step(1);
    chk("R4", "fault after full run", fault, 1'b1);
  endtask

  task automatic t_inactive_modes();
    do_reset();
    txd = 1'b0; step(3 * TMO);
    chk("R5", "fault in sleep", fault, 1'b0);
    mode = MODE_STANDBY; step(3 * TMO);
    chk("R5", "fault in standby", fault, 1'b0);
    chk("R5", "irq in standby", irq, 1'b0);
    mode = MODE_NORMAL; step(TMO - 1);
    chk("R5", "fault one short after entry", fault, 1'b0);
    step(1);
    chk("R5", "fault full run after entry", fault, 1'b1);
  endtask

  task automatic t_tick_gating();
    do_reset();
    mode = MODE_NORMAL; tick = 1'b0; txd = 1'b0; step(3 * TMO);
    chk("R12", "fault without ticks", fault, 1'b0);
    tick = 1'b1; step(TMO - 1);
    chk("R12", "fault one tick short", fault, 1'b0);
    step(1);
    chk("R12", "fault at tick limit", fault, 1'b1);
    do_reset();
    mode = MODE_NORMAL; bus = 1'b0; step(2);
    mode = MODE_SLEEP; step(1);
    bus = 1'b1; tick = 1'b0; step(4 * FILT);
    chk("R12", "lock without ticks", wake_lock, 1'b1);
    tick = 1'b1;
  endtask

  task automatic t_sleep_dominant();
    do_reset();
    mode = MODE_NORMAL; bus = 1'b0; step(2);
    mode = MODE_SLEEP; step(1);
    chk("R9", "lock on dominant sleep entry", wake_lock, 1'b1);
    chk("R9", "irq on dominant sleep entry", irq, 1'b1);
    bus = 1'b1; step(FILT);
    chk("R11", "lock at filter count", wake_lock, 1'b1);
    bus = 1'b0; step(1);
    chk("R11", "lock after glitch", wake_lock, 1'b1);
    bus = 1'b1; step(FILT);
    chk("R11", "lock before release", wake_lock, 1'b1);
    step(1);
    chk("R11", "lock released", wake_lock, 1'b0);
    chk("R9", "irq held until clear", irq, 1'b1);
    strobe_clear();
    chk("R9", "irq after clear", irq, 1'b0);
  endtask

  task automatic t_sleep_recessive();
    do_reset();
    mode = MODE_NORMAL; bus = 1'b1; step(2);
    mode = MODE_SLEEP; step(1);
    chk("R10", "lock on recessive entry", wake_lock, 1'b0);
    chk("R10", "irq on recessive entry", irq, 1'b0);
    bus = 1'b0; step(3);
    chk("R10", "lock dominant during sleep", wake_lock, 1'b0);
    chk("R10", "irq dominant during sleep", irq, 1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_clear_rules();
    t_reentry();
    t_recessive_restart();
    t_inactive_modes();
    t_tick_gating();
    t_sleep_dominant();
    t_sleep_recessive();
    summary();
  end

endmodule